// File: doc/BRIEF.md
# Single-Request Burst Memory Target

This block is a memory-backed slave port for a single-threaded processor master. A whole burst is described by one request: the master presents a command (posted write or read), a start byte address, a beat count and an address-order selector. The request is accepted only when no earlier burst is still running. The target then generates every beat address itself, in either wrapping or XOR order.

Write beats arrive on a separate data channel with a valid flag, a last flag and per-byte enables. The target accepts them with its own data-accept signal. Writes are posted, so they never produce a response. A beat that falls outside the backing store is dropped and raises a sticky error line. The master may only clear that line through a dedicated input.

Read beats come back one per cycle with a response code and a last-beat marker. The master cannot stall them. The data width is a parameter.

Top module: `burst_mem_target`

## Requirements
- R1: After reset, req_accept is 1, wd_accept is 0, rd_resp is 00, rd_last is 0 and err_flag is 0.
- R2: The req_cmd encoding is 00 idle, 01 posted write and 10 read. The code 11 is reserved and acts like idle: it is never accepted and starts no burst.
- R3: A request is taken on a rising edge where req_accept is 1 and req_cmd is 01 or 10. From the next cycle, req_accept stays 0 until the burst's final beat has been handled. Any req_cmd presented while busy is ignored.
- R4: With req_seq=0 (wrap), beat n uses word index base | ((s + n) mod L). Here s is the start word index, L is the beat count and base is s with its low log2(L) bits cleared.
- R5: With req_seq=1 (XOR), beat n uses word index s XOR n.
- R6: The start word index is req_addr shifted right by log2(DATA_W/8). req_len is the beat count and must be a power of two from 1 to LEN_MAX (8 by default).
- R7: During a write burst, wd_accept is 1. A beat is consumed on each rising edge with wd_valid=1, and bit k of wd_be enables byte k (bits 8k+7..8k) of wd_data. Cycles with wd_valid=0 consume nothing.
- R8: The response to read beat n is visible after the (n+2)-th rising edge, counting the accept edge as the first. Beats come one per cycle with no back-pressure. A beat in range returns rd_resp=01 with the stored word. rd_last is 1 only on the final beat. Outside a read, rd_resp is 00 and rd_data is 0.
- R9: A read beat whose word index is at or above MEM_WORDS returns rd_resp=11 and rd_data=0. rd_last is still set on the final beat.
- R10: A posted write never changes rd_resp from 00. A write beat whose word index is at or above MEM_WORDS is dropped without touching any stored word, and it sets err_flag.
- R11: err_flag stays set until err_clr is 1 on a rising edge. It reads 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_cmd | input | 2 | Burst command (00 idle, 01 posted write, 10 read) |
| req_addr | input | ADDR_W | Start byte address |
| req_seq | input | 1 | Address order: 0 wrap, 1 XOR |
| req_len | input | CNT_W | Beat count, power of two |
| req_accept | output | 1 | Request taken on this edge when command is active |
| wd_valid | input | 1 | Write beat present |
| wd_data | input | DATA_W | Write beat data |
| wd_be | input | DATA_W/8 | Write byte enables |
| wd_last | input | 1 | Master marks final write beat |
| wd_accept | output | 1 | Write beat taken on this edge when valid |
| rd_resp | output | 2 | Read response code (00 none, 01 data, 11 error) |
| rd_data | output | DATA_W | Read beat data |
| rd_last | output | 1 | Final read beat |
| err_flag | output | 1 | Sticky posted-write error |
| err_clr | input | 1 | Clears err_flag |

## Verification
The bench reads bursts whose wrap starts mid-block and whose XOR sequences hop non-monotonically. A generator that ignored alignment, or confused the two modes, would return words from the wrong addresses.

Partial byte enables and a write with an idle gap in the middle catch a store that writes whole words or consumes phantom beats. An out-of-range write is followed by a read of the word it would alias to. This exposes a design that truncates the index instead of dropping the beat.

The bench also holds a write command during a read, sends the reserved command code, and checks that error replies still carry the last marker. It checks that the error line survives idle cycles and falls only on a clear.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_WR   = 2'b01,
        CMD_RD   = 2'b10,
        CMD_RSV  = 2'b11
    } cmd_e;

    localparam logic [1:0] RSP_NULL = 2'b00;
    localparam logic [1:0] RSP_DVA  = 2'b01;
    localparam logic [1:0] RSP_ERR  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WR   = 2'b01,
        ST_RD   = 2'b10
    } state_e;
endpackage

// File: rtl/bmt_beat_addr.sv
module bmt_beat_addr #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 4
) (
    input  logic [IDX_W-1:0] start_idx,
    input  logic [CNT_W-1:0] len,
    input  logic [CNT_W-1:0] beat,
    input  logic             xor_mode,
    output logic [IDX_W-1:0] beat_idx
);
    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] beat_ext;
    logic [IDX_W-1:0] wrap_idx;
    logic [IDX_W-1:0] xor_idx;

    always_comb begin
        beat_ext = IDX_W'(beat);
        mask     = IDX_W'(len) - IDX_W'(1);
        wrap_idx = (start_idx & ~mask) | ((start_idx + beat_ext) & mask);
        xor_idx  = start_idx ^ beat_ext;
        beat_idx = xor_mode ? xor_idx : wrap_idx;
    end
endmodule

// File: rtl/bmt_store.sv
module bmt_store #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int MI_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MI_W-1:0]   idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTES-1:0]  wbe,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < BYTES; b++) begin
                if (wbe[b]) mem_q[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/burst_mem_target.sv
module burst_mem_target
    import bmt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int MEM_WORDS = 32,
    parameter int LEN_MAX   = 8,
    localparam int BYTES    = DATA_W / 8,
    localparam int OFF_W    = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int IDX_W    = ADDR_W - OFF_W,
    localparam int CNT_W    = $clog2(LEN_MAX) + 1,
    localparam int MI_W     = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    input  logic [CNT_W-1:0]  req_len,
    output logic              req_accept,
    input  logic              wd_valid,
    input  logic [DATA_W-1:0] wd_data,
    input  logic [BYTES-1:0]  wd_be,
    input  logic              wd_last,
    output logic              wd_accept,
    output logic [1:0]        rd_resp,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              err_flag,
    input  logic              err_clr
);
    typedef struct packed {
        state_e            st;
        logic [IDX_W-1:0]  start;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  beat;
        logic              seq;
        logic [1:0]        resp;
        logic [DATA_W-1:0] data;
        logic              last;
        logic              err;
    } regs_t;

    regs_t             r_q, r_d;
    logic [IDX_W-1:0]  cur_idx;
    logic              in_range;
    logic              last_beat;
    logic              mem_we;
    logic [DATA_W-1:0] mem_rdata;
    logic              wr_bad;

    bmt_beat_addr #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_addr (
        .start_idx (r_q.start),
        .len       (r_q.len),
        .beat      (r_q.beat),
        .xor_mode  (r_q.seq),
        .beat_idx  (cur_idx)
    );

    bmt_store #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .idx   (cur_idx[MI_W-1:0]),
        .wdata (wd_data),
        .wbe   (wd_be),
        .rdata (mem_rdata)
    );

    always_comb begin
        r_d        = r_q;
        r_d.resp   = RSP_NULL;
        r_d.data   = '0;
        r_d.last   = 1'b0;
        mem_we     = 1'b0;
        wr_bad     = 1'b0;
        in_range   = {1'b0, cur_idx} < (IDX_W+1)'(MEM_WORDS);
        last_beat  = (r_q.beat == r_q.len - CNT_W'(1));
        req_accept = (r_q.st == ST_IDLE);
        wd_accept  = (r_q.st == ST_WR);

        case (r_q.st)
            ST_IDLE: begin
                if (req_cmd == CMD_WR || req_cmd == CMD_RD) begin
                    r_d.st    = (req_cmd == CMD_WR) ? ST_WR : ST_RD;
                    r_d.start = req_addr[ADDR_W-1:OFF_W];
                    r_d.len   = req_len;
                    r_d.seq   = req_seq;
                    r_d.beat  = '0;
                end
            end
            ST_WR: begin
                if (wd_valid) begin
                    mem_we   = in_range;
                    wr_bad   = !in_range;
                    r_d.beat = r_q.beat + CNT_W'(1);
                    if (last_beat) r_d.st = ST_IDLE;
                end
            end
            ST_RD: begin
                r_d.resp = in_range ? RSP_DVA : RSP_ERR;
                r_d.data = in_range ? mem_rdata : '0;
                r_d.last = last_beat;
                r_d.beat = r_q.beat + CNT_W'(1);
                if (last_beat) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (wr_bad)       r_d.err = 1'b1;
        else if (err_clr) r_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_resp  = r_q.resp;
    assign rd_data  = r_q.data;
    assign rd_last  = r_q.last;
    assign err_flag = r_q.err;

    // R3: a taken request makes the port busy on the next cycle
    a_r3_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && (req_cmd == CMD_WR || req_cmd == CMD_RD)) |=> !req_accept);

    // R6: only power-of-two lengths within range are taken
    a_r6_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && (req_cmd == CMD_WR || req_cmd == CMD_RD))
        |-> ($countones(req_len) == 1 && req_len <= CNT_W'(LEN_MAX)));

    // R7: master's last flag agrees with the target's beat count
    a_r7_last_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_accept && wd_valid && wd_last) |=> req_accept);

    // R8: the last marker is a single-cycle pulse
    a_r8_last_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |=> !rd_last);

    // R8: the last marker always rides on a real response
    a_r8_last_has_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_resp != RSP_NULL);

    // R10: no response while a posted write is in progress
    a_r10_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        wd_accept |-> rd_resp == RSP_NULL);

    // R11: error line holds without a clear
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);
endmodule

// File: tb/sim_burst_mem_target.sv
`timescale 1ns/1ps
module sim_burst_mem_target;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int NW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    req_cmd = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          req_seq = 1'b0;
    logic [CW-1:0] req_len = '0;
    logic          req_accept;
    logic          wd_valid = 1'b0;
    logic [DW-1:0] wd_data = '0;
    logic [3:0]    wd_be = '0;
    logic          wd_last = 1'b0;
    logic          wd_accept;
    logic [1:0]    rd_resp;
    logic [DW-1:0] rd_data;
    logic          rd_last;
    logic          err_flag;
    logic          err_clr = 1'b0;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] model [NW];

    always #2.5 clk = ~clk;

    burst_mem_target u0 (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_addr(req_addr),
        .req_seq(req_seq), .req_len(req_len), .req_accept(req_accept),
        .wd_valid(wd_valid), .wd_data(wd_data), .wd_be(wd_be), .wd_last(wd_last),
        .wd_accept(wd_accept), .rd_resp(rd_resp), .rd_data(rd_data),
        .rd_last(rd_last), .err_flag(err_flag), .err_clr(err_clr)
    );

    // read vectors: {start word[5:0], xor, len[3:0]}
    localparam logic [10:0] RD_VEC [8] = '{
        {6'd5,  1'b0, 4'd4}, {6'd13, 1'b1, 4'd8},
        {6'd0,  1'b0, 4'd1}, {6'd7,  1'b0, 4'd8},
        {6'd6,  1'b1, 4'd2}, {6'd27, 1'b1, 4'd4},
        {6'd30, 1'b0, 4'd2}, {6'd3,  1'b1, 4'd1}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int word_of(int s, bit x, int len, int n);
        if (x) return s ^ n;
        return (s - (s % len)) + ((s + n) % len);
    endfunction

    task automatic wr_burst(int s, bit x, int len, logic [DW-1:0] seed,
                            logic [3:0] be, bit gap);
        @(negedge clk);
        req_cmd = 2'b01; req_addr = AW'(s * 4); req_seq = x; req_len = CW'(len);
        @(posedge clk);
        @(negedge clk);
        req_cmd = 2'b00;
        check("R7 wd_accept in write", wd_accept, 1);
        for (int n = 0; n < len; n++) begin
            if (gap && n == 1) begin
                wd_valid = 1'b0;
                @(posedge clk);
                @(negedge clk);
            end
            wd_valid = 1'b1;
            wd_data  = seed ^ (DW'(n) * 32'h0101_0101);
            wd_be    = be;
            wd_last  = (n == len - 1);
            @(posedge clk);
            begin
                int w = word_of(s, x, len, n);
                if (w < NW) begin
                    for (int b = 0; b < 4; b++)
                        if (be[b]) model[w][8*b +: 8] = wd_data[8*b +: 8];
                end
            end
            @(negedge clk);
            check("R10 no response during write", rd_resp, 2'b00);
        end
        wd_valid = 1'b0; wd_last = 1'b0;
        check("R7 wd_accept drops after burst", wd_accept, 0);
    endtask

    task automatic rd_burst(int s, bit x, int len);
        @(negedge clk);
        req_cmd = 2'b10; req_addr = AW'(s * 4); req_seq = x; req_len = CW'(len);
        check("R3 accept when idle", req_accept, 1);
        @(posedge clk);
        @(negedge clk);
        req_cmd = 2'b01;
        check("R3 busy after accept", req_accept, 0);
        for (int n = 0; n < len; n++) begin
            int w;
            @(posedge clk);
            @(negedge clk);
            w = word_of(s, x, len, n);
            if (w < NW) begin
                check(x ? "R5 xor resp" : "R4 wrap resp", rd_resp, 2'b01);
                check(x ? "R5 xor data" : "R4 wrap data", rd_data, model[w]);
            end else begin
                check("R9 error resp", rd_resp, 2'b11);
                check("R9 error data", rd_data, 0);
            end
            check("R8 last marker", rd_last, (n == len - 1));
            if (n == len - 1) req_cmd = 2'b00;
        end
        @(posedge clk);
        @(negedge clk);
        check("R8 idle resp", rd_resp, 2'b00);
        check("R3 busy command ignored", wd_accept, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 req_accept", req_accept, 1);
        check("R1 wd_accept", wd_accept, 0);
        check("R1 rd_resp", rd_resp, 2'b00);
        check("R1 rd_last", rd_last, 0);
        check("R1 err_flag", err_flag, 0);
        rst_n = 1'b1;

        // R6: fill store using byte address -> word index
        for (int k = 0; k < 4; k++)
            wr_burst(k * 8, 1'b0, 8, 32'hA500_0000 + DW'(k) * 32'h10, 4'hF, 1'b0);
        check("R10 clean writes leave err_flag", err_flag, 0);

        // table walk: R4, R5, R8
        for (int v = 0; v < 8; v++)
            rd_burst(int'(RD_VEC[v][10:5]), RD_VEC[v][4], int'(RD_VEC[v][3:0]));

        // R7: partial byte enables
        wr_burst(5, 1'b0, 1, 32'h1122_3344, 4'b0101, 1'b0);
        rd_burst(5, 1'b0, 1);

        // R7 and R5: XOR-order write with an idle gap
        wr_burst(9, 1'b1, 4, 32'hC0DE_0000, 4'hF, 1'b1);
        rd_burst(8, 1'b0, 4);

        // R9: read fully outside the store
        rd_burst(40, 1'b0, 4);

        // R10: out-of-range write sets error, aliased words untouched
        wr_burst(33, 1'b0, 2, 32'hDEAD_BEEF, 4'hF, 1'b0);
        check("R10 err set by bad write", err_flag, 1);
        rd_burst(0, 1'b0, 2);

        // R11: sticky, then cleared
        repeat (4) @(negedge clk);
        check("R11 err stays set", err_flag, 1);
        err_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        err_clr = 1'b0;
        check("R11 err cleared", err_flag, 0);

        // R2: reserved code starts nothing
        req_cmd = 2'b11;
        @(posedge clk);
        @(negedge clk);
        check("R2 reserved keeps accept", req_accept, 1);
        check("R2 reserved no write", wd_accept, 0);
        @(posedge clk);
        @(negedge clk);
        req_cmd = 2'b00;
        check("R2 reserved no response", rd_resp, 2'b00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule